// File: doc/BRIEF.md
# Asynchronous Backplane Slave Controller

This block is the slave side of an 8-bit backplane with a fully interlocked strobe and acknowledge handshake. A master places a 20-bit address and qualifies it with an active-low address strobe. It then presents a 3-bit coded command and qualifies that with an active-low data strobe. The controller brings the strobes, the command lines and the bus reset into its own clock through a two-flop synchronizer. It then decodes the cycle against a memory window, an I/O window and one vector-fetch level, all set by parameters.

On a selected cycle the controller latches the address, command and write data. It waits a parameterised number of local wait states, then issues a single-cycle local write or read strobe. On a read it captures the local data one cycle later. It then asserts acknowledge, or the transfer-error line if the local side reported a fault. On a read it also enables its data drivers. Both the response and the data are held until the master releases the data strobe. Unselected cycles and reserved command codes leave every output idle.

Top module: `async_bus_slave`

## Requirements
- R1: The command code selects the cycle: 3'b111 memory read, 3'b110 memory write, 3'b101 I/O read, 3'b100 I/O write, 3'b011 vector fetch (a read). `loc_space_o` reports 1 for memory, 2 for I/O and 3 for vector.
- R2: Codes 3'b000, 3'b001 and 3'b010 get no acknowledge and no transfer error, cause no local strobe and leave the data bus undriven.
- R3: A memory cycle is selected only when address bits [19:MEM_AW] equal those of MEM_BASE. `loc_addr_o` then carries the full 20-bit address.
- R4: An I/O cycle uses only address bits [11:0], and bits [19:12] have no effect. It is selected when bits [11:IO_AW] equal those of IO_BASE, and `loc_addr_o` has its bits [19:12] at zero.
- R5: A vector fetch is answered only when address bits [2:0] equal VEC_LEVEL, with `loc_addr_o` equal to that level. It returns the local read data.
- R6: A write cycle gives exactly one single-cycle `loc_we_o` pulse, with the bus address and the bus write data presented on the local outputs.
- R7: A read cycle gives exactly one `loc_re_o` pulse. `data_o` then carries the local read data, and `data_oe_o` is high while acknowledge is asserted.
- R8: Acknowledge, and any read data, stay asserted while the data strobe stays asserted. Once the strobe is released they are still asserted two clocks later and released on the third.
- R9: With both strobes asserted together, acknowledge is first seen 6 + WAIT_STATES clocks later.
- R10: If `loc_err_i` is high when the read data is captured, the transfer-error line is asserted in place of acknowledge. The data bus stays undriven, and the error is held by the same interlock as acknowledge.
- R11: While the bus reset is asserted, no cycle is answered. Asserting the bus reset during a held acknowledge releases it within three clocks, even with the data strobe still asserted.
- R12: Acknowledge and transfer error are never asserted together, and `data_oe_o` is high only while acknowledge is asserted.
- R13: A data strobe without the address strobe gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock |
| rst_ni | input | 1 | Asynchronous active-low local reset |
| bus_rst_ni | input | 1 | Active-low backplane system reset |
| addr_i | input | 20 | Backplane address |
| adr_stb_ni | input | 1 | Active-low address strobe |
| dat_stb_ni | input | 1 | Active-low data strobe |
| cmd_i | input | 3 | Coded command |
| data_i | input | 8 | Data bus as received |
| data_o | output | 8 | Read data towards the data bus |
| data_oe_o | output | 1 | Data bus driver enable |
| ack_no | output | 1 | Active-low transfer acknowledge |
| terr_no | output | 1 | Active-low transfer error |
| loc_addr_o | output | 20 | Local address of the current cycle |
| loc_space_o | output | 2 | Local address space (1 memory, 2 I/O, 3 vector) |
| loc_wdata_o | output | 8 | Local write data |
| loc_we_o | output | 1 | Single-cycle local write strobe |
| loc_re_o | output | 1 | Single-cycle local read strobe |
| loc_rdata_i | input | 8 | Local read data, valid the cycle after loc_re_o |
| loc_err_i | input | 1 | Local fault, sampled with the read data |

## Verification
The hardest situation to reach is a bus reset that arrives while an acknowledge is being held and the master still keeps its data strobe asserted. Nothing in the normal handshake ends that cycle. The bench therefore starts a selected read, waits until acknowledge appears, and only then lowers the bus reset while leaving both strobes asserted. It then checks that the response falls away within the synchronizer delay and that no new cycle starts. A second hard case is the boundary of each window, just inside and just outside, together with an I/O address whose upper twelve-to-nineteen bits are all nonzero.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  localparam logic [2:0] CMD_MEM_RD = 3'b111;
  localparam logic [2:0] CMD_MEM_WR = 3'b110;
  localparam logic [2:0] CMD_IO_RD  = 3'b101;
  localparam logic [2:0] CMD_IO_WR  = 3'b100;
  localparam logic [2:0] CMD_VEC    = 3'b011;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_MEM  = 2'd1,
    SP_IO   = 2'd2,
    SP_VEC  = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACCESS,
    ST_RESP,
    ST_HOLD,
    ST_IGNORE
  } state_e;
endpackage

// File: rtl/bsl_sync.sv
module bsl_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bsl_decode.sv
module bsl_decode
  import bsl_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 20,
  parameter int unsigned       IO_W     = 12,
  parameter int unsigned       VEC_W    = 3,
  parameter logic [ADDR_W-1:0] MEM_BASE = 20'h4_0000,
  parameter int unsigned       MEM_AW   = 12,
  parameter logic [IO_W-1:0]   IO_BASE  = 12'h300,
  parameter int unsigned       IO_AW    = 4,
  parameter logic [VEC_W-1:0]  VEC_LVL  = 3'd5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        cmd_i,
  output logic              hit_o,
  output logic              rd_o,
  output space_e            space_o,
  output logic [ADDR_W-1:0] loc_addr_o
);
  logic mem_cmd, io_cmd, vec_cmd;
  logic mem_win, io_win, vec_win;

  assign mem_cmd = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
  assign io_cmd  = (cmd_i == CMD_IO_RD)  || (cmd_i == CMD_IO_WR);
  assign vec_cmd = (cmd_i == CMD_VEC);

  assign mem_win = addr_i[ADDR_W-1:MEM_AW] == MEM_BASE[ADDR_W-1:MEM_AW];
  assign io_win  = addr_i[IO_W-1:IO_AW]    == IO_BASE[IO_W-1:IO_AW];
  assign vec_win = addr_i[VEC_W-1:0]       == VEC_LVL;

  always_comb begin
    hit_o      = 1'b0;
    space_o    = SP_NONE;
    loc_addr_o = '0;
    if (mem_cmd && mem_win) begin
      hit_o      = 1'b1;
      space_o    = SP_MEM;
      loc_addr_o = addr_i;
    end else if (io_cmd && io_win) begin
      hit_o      = 1'b1;
      space_o    = SP_IO;
      loc_addr_o = ADDR_W'(addr_i[IO_W-1:0]);
    end else if (vec_cmd && vec_win) begin
      hit_o      = 1'b1;
      space_o    = SP_VEC;
      loc_addr_o = ADDR_W'(addr_i[VEC_W-1:0]);
    end
  end

  // reads: memory read, I/O read, vector fetch
  assign rd_o = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_IO_RD) || vec_cmd;
endmodule

// File: rtl/bsl_seq.sv
module bsl_seq
  import bsl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WAIT_STATES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              dat_act_i,
  input  logic              brst_act_i,
  input  logic              hit_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] loc_rdata_i,
  input  logic              loc_err_i,
  output logic              lat_en_o,
  output logic              loc_we_o,
  output logic              loc_re_o,
  output logic              ack_o,
  output logic              terr_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

  state_e             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q;
  logic               rd_q, err_q;
  logic [DATA_W-1:0]  rdata_q;

  always_comb begin
    state_d  = state_q;
    lat_en_o = 1'b0;
    if (brst_act_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          if (hit_i) begin
            state_d  = ST_WAIT;
            lat_en_o = 1'b1;
          end else begin
            state_d = ST_IGNORE;
          end
        end
        ST_WAIT: begin
          if (!dat_act_i)        state_d = ST_IDLE;
          else if (cnt_q == '0)  state_d = ST_ACCESS;
        end
        ST_ACCESS: state_d = ST_RESP;
        ST_RESP:   state_d = ST_HOLD;
        ST_HOLD:   if (!dat_act_i) state_d = ST_IDLE;
        ST_IGNORE: if (!dat_act_i) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (lat_en_o) begin
        cnt_q <= CNT_W'(WAIT_STATES);
        rd_q  <= rd_i;
        err_q <= 1'b0;
      end else if (state_q == ST_WAIT && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (state_q == ST_RESP) begin
        err_q   <= loc_err_i;
        rdata_q <= rd_q ? loc_rdata_i : '0;
      end
    end
  end

  assign loc_we_o = (state_q == ST_ACCESS) && !rd_q;
  assign loc_re_o = (state_q == ST_ACCESS) &&  rd_q;
  assign ack_o    = (state_q == ST_HOLD) && !err_q;
  assign terr_o   = (state_q == ST_HOLD) &&  err_q;
  assign oe_o     = ack_o && rd_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/async_bus_slave.sv
module async_bus_slave
  import bsl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IO_W        = 12,
  parameter int unsigned VEC_W       = 3,
  parameter logic [19:0] MEM_BASE    = 20'h4_0000,
  parameter int unsigned MEM_AW      = 12,
  parameter logic [11:0] IO_BASE     = 12'h300,
  parameter int unsigned IO_AW       = 4,
  parameter logic [2:0]  VEC_LVL     = 3'd5,
  parameter int unsigned WAIT_STATES = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adr_stb_ni,
  input  logic              dat_stb_ni,
  input  logic [2:0]        cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_no,
  output logic              terr_no,
  output logic [ADDR_W-1:0] loc_addr_o,
  output logic [1:0]        loc_space_o,
  output logic [DATA_W-1:0] loc_wdata_o,
  output logic              loc_we_o,
  output logic              loc_re_o,
  input  logic [DATA_W-1:0] loc_rdata_i,
  input  logic              loc_err_i
);
  localparam int unsigned SYNC_W = 6;

  logic [SYNC_W-1:0] sync_q;
  logic              brst_s_n, adr_s_n, dat_s_n;
  logic [2:0]        cmd_s;
  logic              hit, rd, lat_en, ack, terr;
  space_e            space, space_q;
  logic [ADDR_W-1:0] dec_addr, addr_q;
  logic [DATA_W-1:0] wdata_q;

  bsl_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(6'b011_000)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({bus_rst_ni, adr_stb_ni, dat_stb_ni, cmd_i}),
    .q_o   (sync_q)
  );

  assign {brst_s_n, adr_s_n, dat_s_n, cmd_s} = sync_q;

  // address is stable while its strobe is held; sampled raw
  bsl_decode #(
    .ADDR_W  (ADDR_W),
    .IO_W    (IO_W),
    .VEC_W   (VEC_W),
    .MEM_BASE(MEM_BASE),
    .MEM_AW  (MEM_AW),
    .IO_BASE (IO_BASE),
    .IO_AW   (IO_AW),
    .VEC_LVL (VEC_LVL)
  ) u_dec (
    .addr_i    (addr_i),
    .cmd_i     (cmd_s),
    .hit_o     (hit),
    .rd_o      (rd),
    .space_o   (space),
    .loc_addr_o(dec_addr)
  );

  bsl_seq #(
    .DATA_W     (DATA_W),
    .WAIT_STATES(WAIT_STATES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (!adr_s_n && !dat_s_n),
    .dat_act_i  (!dat_s_n),
    .brst_act_i (!brst_s_n),
    .hit_i      (hit),
    .rd_i       (rd),
    .loc_rdata_i(loc_rdata_i),
    .loc_err_i  (loc_err_i),
    .lat_en_o   (lat_en),
    .loc_we_o   (loc_we_o),
    .loc_re_o   (loc_re_o),
    .ack_o      (ack),
    .terr_o     (terr),
    .oe_o       (data_oe_o),
    .rdata_o    (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      space_q <= SP_NONE;
    end else if (lat_en) begin
      addr_q  <= dec_addr;
      wdata_q <= data_i;
      space_q <= space;
    end
  end

  assign loc_addr_o  = addr_q;
  assign loc_wdata_o = wdata_q;
  assign loc_space_o = space_q;
  assign ack_no      = !ack;
  assign terr_no     = !terr;
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_rst_ni,
  input logic       dat_stb_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       ack_no,
  input logic       terr_no,
  input logic       loc_we_o,
  input logic       loc_re_o
);
  // R12
  ack_terr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ack_no && !terr_no));

  // R12
  oe_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !ack_no);

  // R8
  ack_interlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_no) |-> ($past(dat_stb_ni, 3) || !$past(bus_rst_ni, 3)));

  // R6
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_we_o |=> !loc_we_o);

  // R7
  rdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

  // R11
  bus_rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_rst_ni, 3) |-> (ack_no && terr_no && !data_oe_o && !loc_we_o && !loc_re_o));
endmodule

bind async_bus_slave bsl_checker chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_rst_ni(bus_rst_ni),
  .dat_stb_ni(dat_stb_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .ack_no    (ack_no),
  .terr_no   (terr_no),
  .loc_we_o  (loc_we_o),
  .loc_re_o  (loc_re_o)
);

// File: tb/async_bus_slave_tb_top.sv
module async_bus_slave_tb_top;
  localparam int W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst_n = 1'b1;
  logic [19:0] addr = '0;
  logic        adr_n = 1'b1, dat_n = 1'b1;
  logic [2:0]  cmd = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        oe, ack_n, terr_n;
  logic [19:0] laddr;
  logic [1:0]  lspace;
  logic [7:0]  lwdata, lrdata;
  logic        lwe, lre;
  logic        lerr = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [19:0] we_addr;
  logic [7:0]  we_data;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_model(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign lrdata = mem_model(laddr);

  async_bus_slave #(.WAIT_STATES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_ni(bus_rst_n),
    .addr_i(addr), .adr_stb_ni(adr_n), .dat_stb_ni(dat_n), .cmd_i(cmd),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .ack_no(ack_n), .terr_no(terr_n),
    .loc_addr_o(laddr), .loc_space_o(lspace), .loc_wdata_o(lwdata),
    .loc_we_o(lwe), .loc_re_o(lre), .loc_rdata_i(lrdata), .loc_err_i(lerr));

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // local strobe monitor
  always @(posedge clk) begin
    if (lwe) begin we_cnt++; we_addr = laddr; we_data = lwdata; end
    if (lre) re_cnt++;
  end

  // per-clock invariant model (R12)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(!(!ack_n && !terr_n), "R12 ack/terr exclusive", {ack_n, terr_n}, 2'b11);
      chk(!oe || !ack_n, "R12 oe only with ack", oe, 0);
    end
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic xfer(input logic [2:0] c, input logic [19:0] a, input logic [7:0] wd,
                      input logic le, input logic use_adr, input logic exp_hit,
                      input string tag);
    logic [19:0] ea;
    logic [1:0]  esp;
    logic        rd;
    int          first;
    rd = c[0];
    if (c[2:1] == 2'b11)      begin ea = a;                  esp = 2'd1; end
    else if (c[2:1] == 2'b10) begin ea = {8'h0, a[11:0]};    esp = 2'd2; end
    else                      begin ea = {17'h0, a[2:0]};    esp = 2'd3; end
    @(negedge clk);
    we_cnt = 0; re_cnt = 0;
    addr = a; cmd = c; din = wd; lerr = le;
    adr_n = !use_adr; dat_n = 1'b0;
    first = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (!ack_n || !terr_n) begin first = k; break; end
    end
    if (exp_hit) begin
      chk(first == 6 + W, {tag, " R9 latency"}, first, 6 + W);
      chk(lspace == esp, {tag, " R1 space"}, lspace, esp);
      if (le) begin
        chk(!terr_n && ack_n && !oe, {tag, " R10 terr instead of ack"},
            {terr_n, ack_n, oe}, 3'b010);
      end else begin
        chk(!ack_n, {tag, " R1 ack"}, ack_n, 0);
      end
      if (rd) begin
        chk(re_cnt == 1 && we_cnt == 0, {tag, " R7 one read strobe"}, re_cnt, 1);
        chk(laddr == ea, {tag, " R3/R4/R5 local addr"}, laddr, ea);
        if (!le) chk(oe && dout == mem_model(ea), {tag, " R7 read data"}, dout, mem_model(ea));
      end else begin
        chk(we_cnt == 1 && re_cnt == 0, {tag, " R6 one write strobe"}, we_cnt, 1);
        chk(we_addr == ea && we_data == wd, {tag, " R6 write addr/data"},
            {we_addr, we_data}, {ea, wd});
      end
      repeat (5) @(negedge clk);
      chk(!ack_n || !terr_n, {tag, " R8 held while strobe"}, {ack_n, terr_n}, 0);
      adr_n = 1'b1; dat_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(!ack_n || !terr_n, {tag, " R8 held 2 clocks after release"}, {ack_n, terr_n}, 0);
      @(negedge clk);
      chk(ack_n && terr_n && !oe, {tag, " R8 released"}, {ack_n, terr_n, oe}, 3'b110);
    end else begin
      chk(first == 0 && ack_n && terr_n && !oe && we_cnt == 0 && re_cnt == 0,
          {tag, " no response"}, {first[7:0], we_cnt[3:0], re_cnt[3:0]}, 0);
      adr_n = 1'b1; dat_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    lerr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ack_n && terr_n && !oe, "R12 reset state", {ack_n, terr_n, oe}, 3'b110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    xfer(3'b110, 20'h40123, 8'h9E, 0, 1, 1, "R1 R6 mem write");
    xfer(3'b111, 20'h40FFF, 8'h00, 0, 1, 1, "R1 R7 mem read top");
    xfer(3'b111, 20'h40000, 8'h00, 0, 1, 1, "R3 mem read base");
    xfer(3'b111, 20'h41000, 8'h00, 0, 1, 0, "R3 mem above window");
    xfer(3'b110, 20'h3FFFF, 8'h44, 0, 1, 0, "R3 mem below window");
    xfer(3'b100, 20'hAB305, 8'h11, 0, 1, 1, "R4 io write upper ignored");
    xfer(3'b101, 20'h0030F, 8'h00, 0, 1, 1, "R4 io read top");
    xfer(3'b101, 20'hFF310, 8'h00, 0, 1, 0, "R4 io above window");
    xfer(3'b011, 20'h00005, 8'h00, 0, 1, 1, "R5 vector match");
    xfer(3'b011, 20'h00004, 8'h00, 0, 1, 0, "R5 vector other level");
    xfer(3'b000, 20'h40010, 8'h00, 0, 1, 0, "R2 reserved 000");
    xfer(3'b001, 20'h40010, 8'h00, 0, 1, 0, "R2 reserved 001");
    xfer(3'b010, 20'h40010, 8'h00, 0, 1, 0, "R2 reserved 010");
    xfer(3'b111, 20'h40055, 8'h00, 1, 1, 1, "R10 local error read");
    xfer(3'b100, 20'h00301, 8'h77, 1, 1, 1, "R10 local error write");
    xfer(3'b111, 20'h40020, 8'h00, 0, 0, 0, "R13 no address strobe");

    // R11: bus reset blocks a cycle
    bus_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    xfer(3'b111, 20'h40020, 8'h00, 0, 1, 0, "R11 during bus reset");
    bus_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: bus reset aborts a held acknowledge
    addr = 20'h40033; cmd = 3'b111; lerr = 1'b0;
    adr_n = 1'b0; dat_n = 1'b0;
    repeat (6 + W) @(negedge clk);
    chk(!ack_n, "R11 ack before abort", ack_n, 0);
    bus_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ack_n && !oe, "R11 abort releases ack", {ack_n, oe}, 2'b10);
    repeat (6) @(negedge clk);
    chk(ack_n && terr_n, "R11 no restart under reset", {ack_n, terr_n}, 2'b11);
    adr_n = 1'b1; dat_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(3'b111, 20'h40AAA, 8'h00, 0, 1, 1, "R11 recovery read");

    done = 1;
    summary();
    $finish;
  end
endmodule